// File: doc/BRIEF.md
# Host-Firmware Redirection Line Status

This block produces the line status byte of a serial-port-like mailbox that links a host to embedded firmware. There is no serial line. The firmware places bytes in a receive path that the host drains, and the host places bytes in a transmit path that the firmware drains. Each path is either one holding register (single-register mode) or a 16-entry FIFO (FIFO mode). The host picks the mode with a level input.

The block builds its status bits from register and FIFO activity and from firmware pulses:

- data ready,
- holding empty and transmitter idle,
- break,
- overrun,
- a FIFO-mode receive error flag.

The host reads the status as one 8-bit byte. A host read of that byte returns the value held before the read. After the read, break and overrun clear, unless the firmware raises one of them again in that same cycle.

The block resets on a synchronous host reset. It also resets when its power-state input moves from the deepest sleep state straight to the fully-on state.

Top module: `hfr_line_status`

## Requirements
- R1: `rst`, or a cycle where `pm_state` moves from 2'b11 (deepest sleep) to 2'b00 (fully on), returns the status byte to 8'h00 and empties both paths. Any other power-state move leaves the status unchanged.
- R2: In single-register mode, a firmware receive write stores the byte and sets bit 0 (data ready). A host receive read clears bit 0. `host_rx_data` shows the stored byte.
- R3: In FIFO mode, bit 0 is high exactly while the receive FIFO holds data. Bytes come out in arrival order. The FIFO holds 16 bytes, and a write to a full FIFO is dropped.
- R4: In single-register mode, a host transmit write stores the byte and clears holding-empty (bit 5). A firmware transmit read sets bit 5. `fw_tx_data` shows the stored byte.
- R5: In FIFO mode, bit 5 is high exactly while the transmit FIFO is empty. The firmware receives the bytes in host write order.
- R6: Changing `host_fifo_mode` does four things:
  - forces holding-empty high,
  - flushes both FIFOs,
  - clears the single-register data-ready flag,
  - ignores data accesses in that cycle.
- R7: Bit 6 (transmitter idle) always equals bit 5. Both read 0 while `fw_thr_en` is low.
- R8: Bit 4 (break) is set by `fw_brk_fifo` in FIFO mode and by `fw_brk_reg` in single-register mode. The other pulse has no effect. Bit 4 clears after a host status read, unless it is set again in that cycle.
- R9: Bit 1 (overrun) is set by `fw_ovr_set` and clears after a host status read. A set in the same cycle as the read wins. The read returns the pre-clear value.
- R10: Bits 3:2 always read 0. Bit 7 reads 0 in single-register mode and equals bit 4 in FIFO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high host reset |
| pm_state | input | 2 | Power state, 2'b00 fully on, 2'b11 deepest sleep |
| host_fifo_mode | input | 1 | Host mode select, 1 = FIFO mode |
| host_lsr_rd | input | 1 | Host reads the status byte this cycle |
| host_lsr | output | 8 | Status byte |
| host_rx_rd | input | 1 | Host reads the receive path |
| host_rx_data | output | 8 | Receive byte seen by the host |
| host_tx_wr | input | 1 | Host writes the transmit path |
| host_tx_data | input | 8 | Transmit byte from the host |
| fw_rx_wr | input | 1 | Firmware writes the receive path |
| fw_rx_data | input | 8 | Receive byte from the firmware |
| fw_tx_rd | input | 1 | Firmware reads the transmit path |
| fw_tx_data | output | 8 | Transmit byte seen by the firmware |
| fw_thr_en | input | 1 | Firmware enables holding-empty reporting |
| fw_brk_fifo | input | 1 | Break set pulse used in FIFO mode |
| fw_brk_reg | input | 1 | Break set pulse used in single-register mode |
| fw_ovr_set | input | 1 | Overrun set pulse |

## Verification
The hardest case is a firmware set pulse that lands in the very cycle the host reads the status byte. The read has to show the old value while the bit still stays set afterwards. The stimulus drives both inputs on the same falling edge and samples the byte before and after the next rising edge.

A second hard case is the mode-change flush with data still queued. The bench fills the receive FIFO and leaves a byte in the transmit FIFO, then toggles the mode in both directions. It then checks that data ready drops and holding-empty rises.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

    typedef enum logic [1:0] {
        PM_D0 = 2'b00,
        PM_D1 = 2'b01,
        PM_D2 = 2'b10,
        PM_D3 = 2'b11
    } pm_state_e;

    // Status byte layout, most significant field first
    typedef struct packed {
        logic       rx_err;     // bit 7
        logic       tx_idle;    // bit 6
        logic       hold_empty; // bit 5
        logic       brk;        // bit 4
        logic [1:0] rsvd;       // bits 3:2
        logic       ovr;        // bit 1
        logic       ready;      // bit 0
    } lsr_t;

    function automatic lsr_t build_status(
        input logic fifo_mode,
        input logic ready,
        input logic hold_empty,
        input logic thr_en,
        input logic brk,
        input logic ovr
    );
        lsr_t s;
        s            = '0;
        s.ready      = ready;
        s.ovr        = ovr;
        s.brk        = brk;
        s.hold_empty = thr_en & hold_empty;
        s.tx_idle    = s.hold_empty;
        s.rx_err     = fifo_mode & brk;
        s.rsvd       = 2'b00;
        return s;
    endfunction

endpackage

// File: rtl/hfr_rst_ctrl.sv
module hfr_rst_ctrl
    import hfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pm_state,
    output logic       soft_rst
);
    pm_state_e pm_q;
    logic      wake_evt;

    always_ff @(posedge clk) begin
        if (rst) pm_q <= PM_D0;
        else     pm_q <= pm_state_e'(pm_state);
    end

    assign wake_evt = (pm_q == PM_D3) && (pm_state_e'(pm_state) == PM_D0);
    assign soft_rst = rst | wake_evt;
endmodule

// File: rtl/hfr_fifo.sv
module hfr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end
endmodule

// File: rtl/hfr_sticky_flag.sv
module hfr_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd_clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~rd_clr);
    end
endmodule

// File: rtl/hfr_line_status.sv
module hfr_line_status
    import hfr_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pm_state,
    input  logic          host_fifo_mode,
    input  logic          host_lsr_rd,
    output logic [7:0]    host_lsr,
    input  logic          host_rx_rd,
    output logic [DW-1:0] host_rx_data,
    input  logic          host_tx_wr,
    input  logic [DW-1:0] host_tx_data,
    input  logic          fw_rx_wr,
    input  logic [DW-1:0] fw_rx_data,
    input  logic          fw_tx_rd,
    output logic [DW-1:0] fw_tx_data,
    input  logic          fw_thr_en,
    input  logic          fw_brk_fifo,
    input  logic          fw_brk_reg,
    input  logic          fw_ovr_set
);
    logic          soft_rst;
    logic          mode_q, mode_chg, acc_ok;
    logic [DW-1:0] rx_hold, tx_hold, rx_head, tx_head;
    logic          dr_nf, thre_nf;
    logic          rx_empty, tx_empty;
    logic          brk_q, ovr_q, brk_set;
    lsr_t          status;

    hfr_rst_ctrl u_rst (
        .clk      (clk),
        .rst      (rst),
        .pm_state (pm_state),
        .soft_rst (soft_rst)
    );

    // Mode tracking: a change flushes and forces holding-empty
    always_ff @(posedge clk) begin
        if (soft_rst) mode_q <= 1'b0;
        else          mode_q <= host_fifo_mode;
    end

    assign mode_chg = (host_fifo_mode != mode_q);
    assign acc_ok   = ~mode_chg;

    // Receive FIFO: firmware pushes, host pops
    hfr_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (soft_rst),
        .flush (mode_chg),
        .push  (mode_q & acc_ok & fw_rx_wr),
        .wdata (fw_rx_data),
        .pop   (mode_q & acc_ok & host_rx_rd),
        .rdata (rx_head),
        .empty (rx_empty)
    );

    // Transmit FIFO: host pushes, firmware pops
    hfr_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (soft_rst),
        .flush (mode_chg),
        .push  (mode_q & acc_ok & host_tx_wr),
        .wdata (host_tx_data),
        .pop   (mode_q & acc_ok & fw_tx_rd),
        .rdata (tx_head),
        .empty (tx_empty)
    );

    // Single-register receive path
    always_ff @(posedge clk) begin
        if (soft_rst) begin
            rx_hold <= '0;
            dr_nf   <= 1'b0;
        end else if (mode_chg) begin
            dr_nf   <= 1'b0;
        end else if (!mode_q) begin
            if (fw_rx_wr) begin
                rx_hold <= fw_rx_data;
                dr_nf   <= 1'b1;
            end else if (host_rx_rd) begin
                dr_nf   <= 1'b0;
            end
        end
    end

    // Single-register transmit path
    always_ff @(posedge clk) begin
        if (soft_rst) begin
            tx_hold <= '0;
            thre_nf <= 1'b0;
        end else if (mode_chg) begin
            thre_nf <= 1'b1;
        end else if (!mode_q) begin
            if (host_tx_wr) begin
                tx_hold <= host_tx_data;
                thre_nf <= 1'b0;
            end else if (fw_tx_rd) begin
                thre_nf <= 1'b1;
            end
        end
    end

    // Clear-on-read flags; set requests win over the read clear
    assign brk_set = mode_q ? fw_brk_fifo : fw_brk_reg;

    hfr_sticky_flag u_brk (
        .clk    (clk),
        .rst    (soft_rst),
        .set    (brk_set),
        .rd_clr (host_lsr_rd),
        .q      (brk_q)
    );

    hfr_sticky_flag u_ovr (
        .clk    (clk),
        .rst    (soft_rst),
        .set    (fw_ovr_set),
        .rd_clr (host_lsr_rd),
        .q      (ovr_q)
    );

    assign status = build_status(
        mode_q,
        mode_q ? ~rx_empty : dr_nf,
        mode_q ? tx_empty  : thre_nf,
        fw_thr_en,
        brk_q,
        ovr_q
    );

    assign host_lsr     = status;
    assign host_rx_data = mode_q ? rx_head : rx_hold;
    assign fw_tx_data   = mode_q ? tx_head : tx_hold;
endmodule

// File: rtl/hfr_line_status_chk.sv
module hfr_line_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pm_state,
    input logic       host_fifo_mode,
    input logic       host_lsr_rd,
    input logic [7:0] host_lsr,
    input logic       fw_thr_en,
    input logic       fw_brk_fifo,
    input logic       fw_brk_reg,
    input logic       fw_ovr_set
);
    logic [1:0] pm_prev;
    logic       mode_seen;
    logic       wake;

    assign wake = (pm_prev == 2'b11) && (pm_state == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) pm_prev <= 2'b00;
        else     pm_prev <= pm_state;
    end

    always_ff @(posedge clk) begin
        if (rst || wake) mode_seen <= 1'b0;
        else             mode_seen <= host_fifo_mode;
    end

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        host_lsr[3:2] == 2'b00);

    // R10
    rx_err_follow_chk: assert property (@(posedge clk) disable iff (rst)
        host_lsr[7] |-> host_lsr[4]);

    // R7
    tx_idle_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        host_lsr[6] == host_lsr[5]);

    // R7
    thr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !fw_thr_en |-> (host_lsr[6:5] == 2'b00));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst || wake)
        (host_lsr_rd && !fw_ovr_set) |=> !host_lsr[1]);

    // R9
    ovr_set_win_chk: assert property (@(posedge clk) disable iff (rst || wake)
        fw_ovr_set |=> host_lsr[1]);

    // R8
    brk_set_chk: assert property (@(posedge clk) disable iff (rst || wake)
        (fw_brk_fifo && fw_brk_reg) |=> host_lsr[4]);

    // R6
    mode_force_chk: assert property (@(posedge clk) disable iff (rst || wake)
        (host_fifo_mode != mode_seen) |=> (!fw_thr_en || host_lsr[5]));
endmodule

bind hfr_line_status hfr_line_status_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .pm_state       (pm_state),
    .host_fifo_mode (host_fifo_mode),
    .host_lsr_rd    (host_lsr_rd),
    .host_lsr       (host_lsr),
    .fw_thr_en      (fw_thr_en),
    .fw_brk_fifo    (fw_brk_fifo),
    .fw_brk_reg     (fw_brk_reg),
    .fw_ovr_set     (fw_ovr_set)
);

// File: tb/tb_hfr_line_status.sv
module tb_hfr_line_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] pm_state;
    logic       host_fifo_mode, host_lsr_rd, host_rx_rd, host_tx_wr;
    logic [7:0] host_lsr, host_rx_data, host_tx_data;
    logic       fw_rx_wr, fw_tx_rd, fw_thr_en, fw_brk_fifo, fw_brk_reg, fw_ovr_set;
    logic [7:0] fw_rx_data, fw_tx_data;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hfr_line_status dut (
        .clk            (clk),
        .rst            (rst),
        .pm_state       (pm_state),
        .host_fifo_mode (host_fifo_mode),
        .host_lsr_rd    (host_lsr_rd),
        .host_lsr       (host_lsr),
        .host_rx_rd     (host_rx_rd),
        .host_rx_data   (host_rx_data),
        .host_tx_wr     (host_tx_wr),
        .host_tx_data   (host_tx_data),
        .fw_rx_wr       (fw_rx_wr),
        .fw_rx_data     (fw_rx_data),
        .fw_tx_rd       (fw_tx_rd),
        .fw_tx_data     (fw_tx_data),
        .fw_thr_en      (fw_thr_en),
        .fw_brk_fifo    (fw_brk_fifo),
        .fw_brk_reg     (fw_brk_reg),
        .fw_ovr_set     (fw_ovr_set)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        host_lsr_rd = 0; host_rx_rd = 0; host_tx_wr = 0; fw_rx_wr = 0;
        fw_tx_rd = 0; fw_brk_fifo = 0; fw_brk_reg = 0; fw_ovr_set = 0;
    endtask

    task automatic do_reset();
        quiet();
        pm_state = 2'b00; host_fifo_mode = 0; fw_thr_en = 0;
        host_tx_data = 0; fw_rx_data = 0;
        rst = 1;
        cyc(); cyc();
        rst = 0;
        cyc();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset value", host_lsr, 8'h00);
        fw_ovr_set = 1; cyc(); quiet();
        chk("R1 overrun before sleep", host_lsr, 8'h02);
        pm_state = 2'b01; cyc();
        pm_state = 2'b00; cyc();
        chk("R1 light-sleep exit keeps status", host_lsr, 8'h02);
        pm_state = 2'b11; cyc();
        chk("R1 status held in deep sleep", host_lsr, 8'h02);
        pm_state = 2'b00; cyc();
        chk("R1 deep-sleep exit clears", host_lsr, 8'h00);
    endtask

    task automatic t_single_rx();
        do_reset();
        fw_rx_wr = 1; fw_rx_data = 8'h5A; cyc(); quiet();
        chk("R2 ready after fw write", host_lsr, 8'h01);
        chk("R2 rx data", host_rx_data, 8'h5A);
        host_rx_rd = 1; cyc(); quiet();
        chk("R2 ready cleared by host read", host_lsr, 8'h00);
    endtask

    task automatic t_single_tx();
        do_reset();
        fw_thr_en = 1; cyc();
        chk("R4 holding-empty low after reset", host_lsr, 8'h00);
        host_tx_wr = 1; host_tx_data = 8'hA5; cyc(); quiet();
        chk("R4 host write keeps empty low", host_lsr, 8'h00);
        chk("R4 fw sees byte", fw_tx_data, 8'hA5);
        fw_tx_rd = 1; cyc(); quiet();
        chk("R4 fw read sets empty", host_lsr, 8'h60);
        fw_thr_en = 0; cyc();
        chk("R7 disable masks bits 6:5", host_lsr, 8'h00);
        fw_thr_en = 1; cyc();
        chk("R7 re-enable shows bits 6:5", host_lsr, 8'h60);
    endtask

    task automatic t_fifo_rx();
        do_reset();
        host_fifo_mode = 1; cyc();
        chk("R3 empty fifo no ready", host_lsr, 8'h00);
        for (int k = 0; k < 17; k++) begin
            fw_rx_wr = 1; fw_rx_data = 8'(k * 7 + 1); cyc();
        end
        quiet();
        chk("R3 ready with data", host_lsr, 8'h01);
        for (int k = 0; k < 16; k++) begin
            host_rx_rd = 1;
            #1;
            chk("R3 fifo order", host_rx_data, 8'(k * 7 + 1));
            cyc();
        end
        quiet();
        chk("R3 write to full fifo dropped", host_lsr, 8'h00);
    endtask

    task automatic t_fifo_tx();
        do_reset();
        fw_thr_en = 1; host_fifo_mode = 1; cyc();
        chk("R5 empty tx fifo", host_lsr, 8'h60);
        host_tx_wr = 1; host_tx_data = 8'h31; cyc();
        host_tx_data = 8'h32; cyc(); quiet();
        chk("R5 non-empty clears", host_lsr, 8'h00);
        chk("R5 first byte", fw_tx_data, 8'h31);
        fw_tx_rd = 1; cyc(); quiet();
        chk("R5 one left", host_lsr, 8'h00);
        chk("R5 second byte", fw_tx_data, 8'h32);
        fw_tx_rd = 1; cyc(); quiet();
        chk("R5 drained sets empty", host_lsr, 8'h60);
    endtask

    task automatic t_mode_change();
        do_reset();
        fw_thr_en = 1;
        fw_rx_wr = 1; fw_rx_data = 8'h77; cyc(); quiet();
        chk("R6 single ready set", host_lsr, 8'h01);
        host_fifo_mode = 1; cyc();
        chk("R6 switch to fifo", host_lsr, 8'h60);
        fw_rx_wr = 1; fw_rx_data = 8'h10; cyc(); cyc(); quiet();
        host_tx_wr = 1; host_tx_data = 8'h44; cyc(); quiet();
        chk("R6 queued data before switch", host_lsr, 8'h01);
        host_fifo_mode = 0; cyc();
        chk("R6 switch to single forces empty", host_lsr, 8'h60);
        host_fifo_mode = 1; cyc();
        chk("R6 fifos flushed", host_lsr, 8'h60);
        host_fifo_mode = 0; cyc();
        chk("R6 single ready cleared", host_lsr, 8'h60);
    endtask

    task automatic t_break();
        do_reset();
        fw_brk_fifo = 1; cyc(); quiet();
        chk("R8 fifo-mode source ignored in single mode", host_lsr, 8'h00);
        fw_brk_reg = 1; cyc(); quiet();
        chk("R10 break in single mode, bit7 low", host_lsr, 8'h10);
        host_lsr_rd = 1; #1;
        chk("R8 read returns pre-clear", host_lsr, 8'h10);
        cyc(); quiet();
        chk("R8 read clears break", host_lsr, 8'h00);
        host_fifo_mode = 1; cyc();
        fw_brk_reg = 1; cyc(); quiet();
        chk("R8 single-mode source ignored in fifo mode", host_lsr, 8'h00);
        fw_brk_fifo = 1; cyc(); quiet();
        chk("R10 break in fifo mode sets bit7", host_lsr, 8'h90);
        host_lsr_rd = 1; fw_brk_fifo = 1; cyc(); quiet();
        chk("R8 set wins over read", host_lsr, 8'h90);
    endtask

    task automatic t_overrun();
        do_reset();
        fw_ovr_set = 1; cyc(); quiet();
        chk("R9 overrun set", host_lsr, 8'h02);
        host_lsr_rd = 1; fw_ovr_set = 1; #1;
        chk("R9 pre-clear value", host_lsr, 8'h02);
        cyc(); quiet();
        chk("R9 set wins over read", host_lsr, 8'h02);
        host_lsr_rd = 1; cyc(); quiet();
        chk("R9 read clears", host_lsr, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_single_rx();
        t_single_tx();
        t_fifo_rx();
        t_fifo_tx();
        t_mode_change();
        t_break();
        t_overrun();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule